// File: doc/BRIEF.md
# FIFO-Freeness Latency Allowance Scaler

This block sits beside one memory client and decides what latency allowance the arbiter should see for it in each cycle. Software programs a base allowance (8 bits) and three percentage thresholds. As the client's FIFO drains and frees up space, the block lowers the allowance in steps: the full value, then half, then a quarter, then zero. An allowance of zero gives the client the highest priority, so a FIFO that is nearly empty gets served urgently.

The threshold levels are worked out once, when a configuration is loaded. Each one is the percentage times the base allowance divided by 100, truncated to an integer. Each cycle the current freeness is turned into a level in the same units and compared against these stored levels. Scaling only takes effect while a global enable is set and the client asks for scaling. The global enable is held by a reference count. Several requesters can raise enable and disable pulses in the same cycle, and the enable stays set until every enable has been matched by a disable. A parameter can build the block for a client that has no scaling support.

Top module: `fifo_lat_scaler`

## Requirements
- R1: A configuration load in which any of the three percentages is greater than 100 is refused. `cfgReject` goes high for one cycle after the load edge, and the stored allowance and levels do not change. A percentage of exactly 100 is accepted.
- R2: Scaling is active when the global enable is set and `scaleReq` is 1. While it is active and the freeness level is at or below the low level, `effAllow` equals the programmed allowance.
- R3: While scaling is active and the freeness level is above the low level but at or below the mid level, `effAllow` is the programmed allowance shifted right by 1.
- R4: While scaling is active and the freeness level is above the mid level but at or below the high level, `effAllow` is the programmed allowance shifted right by 2.
- R5: While scaling is active and the freeness level is above the high level, `effAllow` is 0.
- R6: Each stored level is pct*allow/100, truncated. The freeness percentage is min(free*100/depth, 100), truncated, and the freeness level is that percentage times allow divided by 100. A value equal to a level falls in the lower band. `effAllow` is registered, so it follows its inputs one clock after the stored configuration.
- R7: Each cycle the reference count goes up by the number of `enReq` bits set and down by the number of `disReq` bits set. `globalEn` is 1 exactly when the count is not zero.
- R8: When the disables in a cycle would take the count below zero, `underflowErr` pulses for one cycle and the count keeps its value. A net change that would exceed the counter's range also leaves the count as it was.
- R9: When `globalEn` is 0 or `scaleReq` is 0, `effAllow` equals the programmed allowance whatever the FIFO freeness is.
- R10: When built with SCALE_CAPABLE=0, the block ignores enable and disable pulses. `globalEn` and `underflowErr` stay 0, and `effAllow` is always the programmed allowance.
- R11: After reset the programmed allowance and `effAllow` are 255, `globalEn` is 0, and both flags are 0.
- R12: A FIFO depth of zero is treated as 0 % free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Load strobe for allowance and percentages |
| cfgAllow | input | 8 | Programmed latency allowance |
| pctLow | input | 8 | Low threshold percentage |
| pctMid | input | 8 | Mid threshold percentage |
| pctHigh | input | 8 | High threshold percentage |
| fifoFree | input | FREE_W | Free entries in the client FIFO |
| fifoDepth | input | FREE_W | Total FIFO depth |
| scaleReq | input | 1 | Client asks for scaling |
| enReq | input | N_REQ | Enable pulses, one per requester |
| disReq | input | N_REQ | Disable pulses, one per requester |
| effAllow | output | 8 | Effective allowance to the arbiter |
| globalEn | output | 1 | Global scaling enable (count non-zero) |
| cfgReject | output | 1 | Pulse: configuration refused |
| underflowErr | output | 1 | Pulse: disable with no outstanding enable |

## Verification
The band selection is exercised with two configurations. With 200 at 20/50/80 over a depth of 100, the levels and the freeness levels are whole numbers, so values just below, exactly on and just above each level show whether ties go to the lower band. With 37 at 10/30/90 over a depth of 64, both the percentage division and the level division truncate, which separates a correct rounding path from one that rounds up or scales in a different order. Further patterns cover freeness above the depth, a depth of zero, a percentage of exactly 100, and `scaleReq` low. The reference count is driven by single pulses, by simultaneous pulses from several requesters, and by a disable with nothing outstanding. An enable that follows the underflow shows that the count did not wrap.

// File: rtl/lat_scale_pkg.sv
package lat_scale_pkg;

  localparam int unsigned ALLOW_W  = 8;
  localparam int unsigned PCT_FULL = 100;
  localparam int unsigned N_LEVELS = 3;

  typedef enum logic [1:0] {
    BAND_FULL    = 2'd0,
    BAND_HALF    = 2'd1,
    BAND_QUARTER = 2'd2,
    BAND_ZERO    = 2'd3
  } band_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgAccept;
    logic scaleActive;
  } ctrlStrb_t;

  // pct (<= 100) times allow, divided by 100, truncated
  function automatic logic [ALLOW_W-1:0] scaleByPct(input logic [7:0] pct,
                                                    input logic [ALLOW_W-1:0] allow);
    logic [15:0] prod;
    logic [15:0] quot;
    prod = 16'(pct) * 16'(allow);
    quot = prod / 16'(PCT_FULL);
    return quot[ALLOW_W-1:0];
  endfunction

  function automatic int unsigned popCount(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += 32'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/lat_scale_ctrl.sv
module lat_scale_ctrl
  import lat_scale_pkg::*;
#(
  parameter int unsigned N_REQ         = 4,
  parameter int unsigned CNT_W         = 4,
  parameter bit          SCALE_CAPABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [7:0]       pctLow,
  input  logic [7:0]       pctMid,
  input  logic [7:0]       pctHigh,
  input  logic             scaleReq,
  input  logic [N_REQ-1:0] enReq,
  input  logic [N_REQ-1:0] disReq,
  output ctrlStrb_t        strb,
  output logic             globalEn,
  output logic             cfgReject,
  output logic             underflowErr
);

  localparam int unsigned SUM_W = CNT_W + $clog2(N_REQ + 1) + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] refCnt;
  logic [N_REQ-1:0] enGated, disGated;
  logic [SUM_W-1:0] nEn, nDis, sumUp, sumNext;
  logic             under, over, pctOk;

  // Non-capable build never sees a request
  assign enGated  = enReq  & {N_REQ{SCALE_CAPABLE}};
  assign disGated = disReq & {N_REQ{SCALE_CAPABLE}};

  assign pctOk = (pctLow  <= 8'(PCT_FULL)) &&
                 (pctMid  <= 8'(PCT_FULL)) &&
                 (pctHigh <= 8'(PCT_FULL));

  always_comb begin
    nEn     = SUM_W'(popCount(32'(enGated)));
    nDis    = SUM_W'(popCount(32'(disGated)));
    sumUp   = SUM_W'(refCnt) + nEn;
    under   = sumUp < nDis;
    sumNext = sumUp - nDis;
    over    = !under && (sumNext > CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt       <= '0;
      underflowErr <= 1'b0;
      cfgReject    <= 1'b0;
    end else begin
      underflowErr <= under;
      cfgReject    <= cfgLoad && !pctOk;
      if (!under && !over) refCnt <= sumNext[CNT_W-1:0];
    end
  end

  assign globalEn         = refCnt != '0;
  assign strb.cfgAccept   = cfgLoad && pctOk;
  assign strb.scaleActive = globalEn && scaleReq;

  // R8: count holds across an underflow
  a_r8_underflow_holds: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |-> refCnt == $past(refCnt));

  // R7: enable only rises after an enable pulse
  a_r7_rise_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(globalEn) |-> $past(|enReq));

  // R7: enable only falls after a disable pulse
  a_r7_fall_needs_disable: assert property (@(posedge clk) disable iff (!rstN)
    $fell(globalEn) |-> $past(|disReq));

  // R1: a reject pulse follows a load request
  a_r1_reject_after_load: assert property (@(posedge clk) disable iff (!rstN)
    cfgReject |-> $past(cfgLoad));

  generate
    if (!SCALE_CAPABLE) begin : g_fixedChk
      // R10: fixed client never enables
      a_r10_never_enabled: assert property (@(posedge clk) disable iff (!rstN)
        !globalEn && !underflowErr);
    end
  endgenerate

endmodule

// File: rtl/lat_scale_dp.sv
module lat_scale_dp
  import lat_scale_pkg::*;
#(
  parameter int unsigned FREE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [ALLOW_W-1:0] cfgAllow,
  input  logic [7:0]         pctLow,
  input  logic [7:0]         pctMid,
  input  logic [7:0]         pctHigh,
  input  logic [FREE_W-1:0]  fifoFree,
  input  logic [FREE_W-1:0]  fifoDepth,
  output logic [ALLOW_W-1:0] effAllow
);

  localparam int unsigned NUM_W = FREE_W + 7;

  logic [ALLOW_W-1:0] allowQ;
  logic [7:0]         cfgPct [N_LEVELS];
  logic [ALLOW_W-1:0] levels [N_LEVELS];
  logic [NUM_W-1:0]   freeNum, pctRaw;
  logic [7:0]         freePct;
  logic [ALLOW_W-1:0] freeLevel, effNext;
  band_e              band;

  assign cfgPct[0] = pctLow;
  assign cfgPct[1] = pctMid;
  assign cfgPct[2] = pctHigh;

  always_ff @(posedge clk) begin
    if (!rstN)               allowQ <= '1;
    else if (strb.cfgAccept) allowQ <= cfgAllow;
  end

  // One level register per threshold, computed at load time
  generate
    for (genvar i = 0; i < N_LEVELS; i++) begin : g_level
      logic [ALLOW_W-1:0] lvl;
      always_ff @(posedge clk) begin
        if (!rstN)               lvl <= '0;
        else if (strb.cfgAccept) lvl <= scaleByPct(cfgPct[i], cfgAllow);
      end
      assign levels[i] = lvl;
    end
  endgenerate

  // Freeness as a percentage, clamped, then in allowance units
  always_comb begin
    freeNum = NUM_W'(fifoFree) * NUM_W'(PCT_FULL);
    pctRaw  = (fifoDepth == '0) ? '0 : freeNum / NUM_W'(fifoDepth);
    freePct = (pctRaw > NUM_W'(PCT_FULL)) ? 8'(PCT_FULL) : pctRaw[7:0];
    freeLevel = scaleByPct(freePct, allowQ);
  end

  // Ties fall to the lower band
  always_comb begin
    if (freeLevel <= levels[0])      band = BAND_FULL;
    else if (freeLevel <= levels[1]) band = BAND_HALF;
    else if (freeLevel <= levels[2]) band = BAND_QUARTER;
    else                             band = BAND_ZERO;
  end

  always_comb begin
    if (!strb.scaleActive) effNext = allowQ;
    else begin
      unique case (band)
        BAND_FULL:    effNext = allowQ;
        BAND_HALF:    effNext = allowQ >> 1;
        BAND_QUARTER: effNext = allowQ >> 2;
        default:      effNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) effAllow <= '1;
    else       effAllow <= effNext;
  end

  // R9: unscaled path passes the programmed value
  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    !strb.scaleActive |=> effAllow == $past(allowQ));

  // R5: top band gives highest priority
  a_r5_zero_band: assert property (@(posedge clk) disable iff (!rstN)
    (strb.scaleActive && band == BAND_ZERO) |=> effAllow == '0);

  // R1: stored allowance only changes on an accepted load
  a_r1_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgAccept |=> $stable(allowQ));

  // R2: never above the programmed value
  a_r2_never_above: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> effAllow <= $past(allowQ));

endmodule

// File: rtl/fifo_lat_scaler.sv
module fifo_lat_scaler
  import lat_scale_pkg::*;
#(
  parameter int unsigned N_REQ         = 4,
  parameter int unsigned CNT_W         = 4,
  parameter int unsigned FREE_W        = 8,
  parameter bit          SCALE_CAPABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [7:0]        cfgAllow,
  input  logic [7:0]        pctLow,
  input  logic [7:0]        pctMid,
  input  logic [7:0]        pctHigh,
  input  logic [FREE_W-1:0] fifoFree,
  input  logic [FREE_W-1:0] fifoDepth,
  input  logic              scaleReq,
  input  logic [N_REQ-1:0]  enReq,
  input  logic [N_REQ-1:0]  disReq,
  output logic [7:0]        effAllow,
  output logic              globalEn,
  output logic              cfgReject,
  output logic              underflowErr
);

  ctrlStrb_t strb;

  lat_scale_ctrl #(
    .N_REQ(N_REQ), .CNT_W(CNT_W), .SCALE_CAPABLE(SCALE_CAPABLE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .pctLow(pctLow), .pctMid(pctMid), .pctHigh(pctHigh),
    .scaleReq(scaleReq), .enReq(enReq), .disReq(disReq),
    .strb(strb), .globalEn(globalEn), .cfgReject(cfgReject),
    .underflowErr(underflowErr)
  );

  lat_scale_dp #(.FREE_W(FREE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgAllow(cfgAllow),
    .pctLow(pctLow), .pctMid(pctMid), .pctHigh(pctHigh),
    .fifoFree(fifoFree), .fifoDepth(fifoDepth), .effAllow(effAllow)
  );

endmodule

// File: tb/test_fifo_lat_scaler.sv
module test_fifo_lat_scaler;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgLoad = 1'b0;
  logic [7:0] cfgAllow = '0, pctLow = '0, pctMid = '0, pctHigh = '0;
  logic [7:0] fifoFree = '0, fifoDepth = '0;
  logic       scaleReq = 1'b0;
  logic [3:0] enReq = '0, disReq = '0;
  logic [7:0] effAllow, effFixed;
  logic       globalEn, cfgReject, underflowErr;
  logic       gEnFixed, rejFixed, ufFixed;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic capGe, capUf, capGeFx, capUfFx;

  always #4 clk = ~clk;

  fifo_lat_scaler i_fifo_lat_scaler (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgAllow(cfgAllow),
    .pctLow(pctLow), .pctMid(pctMid), .pctHigh(pctHigh),
    .fifoFree(fifoFree), .fifoDepth(fifoDepth), .scaleReq(scaleReq),
    .enReq(enReq), .disReq(disReq), .effAllow(effAllow),
    .globalEn(globalEn), .cfgReject(cfgReject), .underflowErr(underflowErr));

  fifo_lat_scaler #(.SCALE_CAPABLE(1'b0)) i_fifo_lat_scaler_fixed (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgAllow(cfgAllow),
    .pctLow(pctLow), .pctMid(pctMid), .pctHigh(pctHigh),
    .fifoFree(fifoFree), .fifoDepth(fifoDepth), .scaleReq(scaleReq),
    .enReq(enReq), .disReq(disReq), .effAllow(effFixed),
    .globalEn(gEnFixed), .cfgReject(rejFixed), .underflowErr(ufFixed));

  typedef struct packed {
    logic [7:0] allow, lo, mi, hi, free, depth;
    logic       sreq;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'd200, 8'd20, 8'd50, 8'd80, 8'd10,  8'd100, 1'b1, 8'd200}, // R2
    '{8'd200, 8'd20, 8'd50, 8'd80, 8'd20,  8'd100, 1'b1, 8'd200}, // R6 tie low
    '{8'd200, 8'd20, 8'd50, 8'd80, 8'd21,  8'd100, 1'b1, 8'd100}, // R3
    '{8'd200, 8'd20, 8'd50, 8'd80, 8'd50,  8'd100, 1'b1, 8'd100}, // R6 tie mid
    '{8'd200, 8'd20, 8'd50, 8'd80, 8'd51,  8'd100, 1'b1, 8'd50},  // R4
    '{8'd200, 8'd20, 8'd50, 8'd80, 8'd80,  8'd100, 1'b1, 8'd50},  // R6 tie high
    '{8'd200, 8'd20, 8'd50, 8'd80, 8'd81,  8'd100, 1'b1, 8'd0},   // R5
    '{8'd200, 8'd20, 8'd50, 8'd80, 8'd150, 8'd100, 1'b1, 8'd0},   // R6 clamp
    '{8'd37,  8'd10, 8'd30, 8'd90, 8'd6,   8'd64,  1'b1, 8'd37},  // R6 trunc
    '{8'd37,  8'd10, 8'd30, 8'd90, 8'd8,   8'd64,  1'b1, 8'd18},  // R3
    '{8'd37,  8'd10, 8'd30, 8'd90, 8'd40,  8'd64,  1'b1, 8'd9},   // R4
    '{8'd37,  8'd10, 8'd30, 8'd90, 8'd58,  8'd64,  1'b1, 8'd9},   // R6 trunc tie
    '{8'd37,  8'd10, 8'd30, 8'd90, 8'd60,  8'd64,  1'b1, 8'd0},   // R5
    '{8'd37,  8'd10, 8'd30, 8'd90, 8'd60,  8'd64,  1'b0, 8'd37},  // R9 no request
    '{8'd200, 8'd20, 8'd50, 8'd80, 8'd50,  8'd0,   1'b1, 8'd200}, // R12
    '{8'd100, 8'd100,8'd100,8'd100,8'd64,  8'd64,  1'b1, 8'd100}  // R1 pct 100
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic applyCfg(input logic [7:0] a, l, m, h);
    @(negedge clk);
    cfgAllow = a; pctLow = l; pctMid = m; pctHigh = h; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] e, input logic [3:0] d);
    @(negedge clk);
    enReq = e; disReq = d;
    @(negedge clk);
    capGe = globalEn; capUf = underflowErr;
    capGeFx = gEnFixed; capUfFx = ufFixed;
    enReq = '0; disReq = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got 1 expected 0");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 effAllow", int'(effAllow), 255);
    check("R11 globalEn", int'(globalEn), 0);
    check("R11 flags", int'({cfgReject, underflowErr}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 after release", int'(effAllow), 255);

    // R9: enable clear, scaling would give zero
    applyCfg(8'd200, 8'd20, 8'd50, 8'd80);
    fifoFree = 8'd90; fifoDepth = 8'd100; scaleReq = 1'b1;
    settle();
    check("R9 enable off", int'(effAllow), 200);

    // R7 reference counting
    pulse(4'b0001, 4'b0000);
    check("R7 first enable", int'(capGe), 1);
    settle();
    check("R5 after enable", int'(effAllow), 0);
    pulse(4'b0110, 4'b0000);
    pulse(4'b0000, 4'b0001);
    check("R7 count two left", int'(capGe), 1);
    pulse(4'b0000, 4'b0100);
    check("R7 count one left", int'(capGe), 1);
    pulse(4'b0000, 4'b0010);
    check("R7 count zero", int'(capGe), 0);
    // R8 underflow
    pulse(4'b0000, 4'b1000);
    check("R8 underflow flag", int'(capUf), 1);
    check("R8 still off", int'(capGe), 0);
    @(negedge clk);
    check("R8 flag one cycle", int'(underflowErr), 0);
    pulse(4'b0001, 4'b0000);
    check("R8 count not wrapped on", int'(capGe), 1);
    pulse(4'b0000, 4'b0001);
    check("R8 count not wrapped off", int'(capGe), 0);
    check("R8 no flag", int'(capUf), 0);

    // Enable for table walk
    pulse(4'b0001, 4'b0000);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fifoFree = VECS[i].free; fifoDepth = VECS[i].depth; scaleReq = VECS[i].sreq;
      applyCfg(VECS[i].allow, VECS[i].lo, VECS[i].mi, VECS[i].hi);
      settle();
      check($sformatf("R2-R6 table entry %0d", i), int'(effAllow), int'(VECS[i].exp));
    end

    // R1 reject keeps old configuration
    fifoFree = 8'd6; fifoDepth = 8'd64; scaleReq = 1'b1;
    applyCfg(8'd37, 8'd10, 8'd30, 8'd90);
    settle();
    check("R1 before reject", int'(effAllow), 37);
    @(negedge clk);
    cfgAllow = 8'd10; pctLow = 8'd20; pctMid = 8'd101; pctHigh = 8'd80; cfgLoad = 1'b1;
    @(negedge clk);
    check("R1 reject pulse", int'(cfgReject), 1);
    cfgLoad = 1'b0;
    @(negedge clk);
    check("R1 reject one cycle", int'(cfgReject), 0);
    settle();
    check("R1 config held", int'(effAllow), 37);

    // R10 fixed variant
    fifoFree = 8'd60;
    settle();
    check("R10 scaled main", int'(effAllow), 0);
    check("R10 fixed allow", int'(effFixed), 37);
    pulse(4'b0010, 4'b0000);
    check("R10 fixed enable ignored", int'(capGeFx), 0);
    pulse(4'b0000, 4'b1111);
    check("R10 fixed no underflow", int'(capUfFx), 0);
    check("R10 fixed still off", int'(capGeFx), 0);

    finish();
  end

endmodule